// File: doc/BRIEF.md
# Variable-Length Instruction Extractor

This block sits between an instruction fetch buffer and a decoder. Fetch delivers the instruction stream in little-endian byte order, four bytes per beat. The block gathers the bytes in a small window, finds the length of the instruction at the head, rebuilds the instruction in decoder order, and hands it on as one left-justified word with a length code. Instructions may be 16, 32, 48 or 64 bits long.

In little-endian storage the halfword that carries the major opcode is the one in window bytes 2 and 3, not bytes 0 and 1. Length analysis therefore always begins there. A 16-bit instruction is taken out of the middle of the window, so bytes 0 and 1 stay at the head for the next analysis. Longer instructions consume bytes from the front of the window, and within each 32-bit group the two halfwords are swapped. A synchronous flush empties the window when fetch is redirected.

Top module: `varlen_extract`

## Requirements
- R1: The length class comes from the major opcode, which is bits [7:2] of window byte 3. Opcodes 0 and 1 give 16 bits (out_len 2'b00). Opcodes 56 and 57 give 48 bits (2'b10). Opcodes 46 and 47 give 64 bits (2'b11). Every other opcode, including 9 and 17, gives 32 bits (2'b01).
- R2: A 16-bit instruction is emitted as out_insn[63:48] = {byte3, byte2}, with all lower bits zero. Accepting it removes only bytes 2 and 3. Old bytes 0 and 1 stay at the head, and old bytes 4 onward move down to become the new bytes 2 onward.
- R3: A 32-bit instruction is emitted as out_insn[63:32] = {byte3, byte2, byte1, byte0}, with the lower bits zero. Accepting it removes bytes 0 to 3.
- R4: A 48-bit instruction is emitted as out_insn[63:16] = {byte3, byte2, byte1, byte0, byte5, byte4}, with the lower bits zero. Accepting it removes bytes 0 to 5.
- R5: A 64-bit instruction is emitted as out_insn = {byte3, byte2, byte1, byte0, byte7, byte6, byte5, byte4}. Accepting it removes bytes 0 to 7.
- R6: out_valid is high only when the window holds at least 4 bytes and at least as many bytes as the head instruction needs.
- R7: A fetch beat carries stream byte j on in_bytes[8j+7:8j]. It is appended to the window when in_valid and in_ready are both high. in_ready is high exactly when the window holds at most BUF_BYTES-4 bytes, so the window never overflows.
- R8: While out_valid is high and out_ready is low, out_valid, out_insn and out_len stay unchanged on the next cycle, unless a flush occurs.
- R9: Flush is synchronous. On the cycle after it, the window is empty, out_valid is low and in_ready is high. Any fetch beat or instruction hand-off offered in the flush cycle is discarded.
- R10: After reset, out_valid is low and in_ready is high.
- R11: A fetch beat and an instruction hand-off in the same cycle both take effect, so the next head instruction can come from the new beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous window clear |
| in_valid | input | 1 | Fetch beat offered |
| in_ready | output | 1 | Window has room for a beat |
| in_bytes | input | 8*FILL_BYTES | Fetch beat, stream byte j in bits [8j+7:8j] |
| out_valid | output | 1 | Head instruction complete |
| out_ready | input | 1 | Decoder takes the instruction |
| out_insn | output | 64 | Assembled instruction, left-justified |
| out_len | output | 2 | Length code: 00=16, 01=32, 10=48, 11=64 |

## Verification
The bench builds the block with BUF_BYTES=10 and FILL_BYTES=4. This is the smallest window that still holds a 64-bit instruction plus a spare halfword. With this size, two beats are enough to make in_ready fall while a 16-bit head is stalled, so back-pressure and stall holding are exercised without long fill sequences. The same sizing leaves a lone halfword in the window after a 16-bit and a 32-bit instruction, which exercises the rule that fewer than four held bytes never produce an output.

// File: rtl/vlx_pkg.sv
package vlx_pkg;

  typedef enum logic [1:0] {
    LEN_16 = 2'b00,
    LEN_32 = 2'b01,
    LEN_48 = 2'b10,
    LEN_64 = 2'b11
  } ilen_e;

  localparam int OPC_W   = 6;
  localparam int MIN_WIN = 4;

  // Major opcode lives in the top six bits of the head halfword's upper byte.
  function automatic logic [OPC_W-1:0] major_of(input logic [7:0] hi_byte);
    return hi_byte[7:2];
  endfunction

  function automatic ilen_e classify(input logic [OPC_W-1:0] opc);
    case (opc)
      6'd0, 6'd1:   return LEN_16;
      6'd46, 6'd47: return LEN_64;
      6'd56, 6'd57: return LEN_48;
      default:      return LEN_32;
    endcase
  endfunction

  // Bytes removed from the window for a given class: 2, 4, 6 or 8.
  function automatic int unsigned span_bytes(input ilen_e len);
    return 2 * (32'(len) + 1);
  endfunction

  // Bytes that must be present before the head can be handed on.
  function automatic int unsigned need_bytes(input ilen_e len);
    return (span_bytes(len) < MIN_WIN) ? MIN_WIN : span_bytes(len);
  endfunction

endpackage

// File: rtl/vlx_classify.sv
module vlx_classify
  import vlx_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic [7:0]       hi_byte,
  output ilen_e            len,
  output logic [CNT_W-1:0] span,
  output logic [CNT_W-1:0] need
);

  logic [OPC_W-1:0] opc;

  assign opc  = major_of(hi_byte);
  assign len  = classify(opc);
  assign span = CNT_W'(span_bytes(len));
  assign need = CNT_W'(need_bytes(len));

endmodule

// File: rtl/vlx_assemble.sv
module vlx_assemble
  import vlx_pkg::*;
(
  input  logic [63:0] head,
  input  ilen_e       len,
  output logic [63:0] insn
);

  // hw[i] is the little-endian halfword made of window bytes 2i+1:2i.
  logic [15:0] hw [4];

  for (genvar i = 0; i < 4; i++) begin : g_hw
    assign hw[i] = head[16*i +: 16];
  end

  // Each 32-bit group is emitted upper halfword first; unused tail is zero.
  always_comb begin
    case (len)
      LEN_16:  insn = {hw[1], 48'h0};
      LEN_32:  insn = {hw[1], hw[0], 32'h0};
      LEN_48:  insn = {hw[1], hw[0], hw[2], 16'h0};
      default: insn = {hw[1], hw[0], hw[3], hw[2]};
    endcase
  end

endmodule

// File: rtl/vlx_window.sv
module vlx_window #(
  parameter int BUF_BYTES  = 12,
  parameter int FILL_BYTES = 4,
  parameter int CNT_W      = $clog2(BUF_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    push,
  input  logic [8*FILL_BYTES-1:0] push_bytes,
  input  logic                    pop,
  input  logic                    pop_mid,
  input  logic [CNT_W-1:0]        pop_span,
  output logic [63:0]             head,
  output logic [CNT_W-1:0]        fill_cnt,
  output logic                    room
);

  localparam int BW = 8 * BUF_BYTES;

  logic [BW-1:0]    data_q, data_d, shifted;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [31:0]      left;

  // Bytes above the count are kept at zero so appends can simply OR in.
  always_comb begin
    left    = 32'(cnt_q);
    shifted = data_q;
    if (pop) begin
      left = left - 32'(pop_span);
      if (pop_mid) begin
        shifted = ((data_q >> 32) << 16) | BW'(data_q[15:0]);
      end else begin
        shifted = data_q >> (8 * 32'(pop_span));
      end
    end
    data_d = shifted;
    if (push) begin
      data_d = shifted | (BW'(push_bytes) << (8 * left));
    end
    cnt_d = cnt_q - (pop ? pop_span : '0) + (push ? CNT_W'(FILL_BYTES) : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      cnt_q  <= '0;
    end else if (flush) begin
      data_q <= '0;
      cnt_q  <= '0;
    end else begin
      data_q <= data_d;
      cnt_q  <= cnt_d;
    end
  end

  assign head     = data_q[63:0];
  assign fill_cnt = cnt_q;
  assign room     = (cnt_q <= CNT_W'(BUF_BYTES - FILL_BYTES));

endmodule

// File: rtl/varlen_extract.sv
module varlen_extract
  import vlx_pkg::*;
#(
  parameter int BUF_BYTES  = 12,
  parameter int FILL_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [8*FILL_BYTES-1:0] in_bytes,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [63:0]             out_insn,
  output logic [1:0]              out_len
);

  localparam int CNT_W = $clog2(BUF_BYTES + 1);

  logic [63:0]      head;
  logic [CNT_W-1:0] fill_cnt;
  logic             room;
  ilen_e            head_len;
  logic [CNT_W-1:0] head_span;
  logic [CNT_W-1:0] head_need;
  logic             head_ready;
  logic             take_beat;
  logic             take_insn;

  vlx_classify #(.CNT_W(CNT_W)) u_cls (
    .hi_byte (head[31:24]),
    .len     (head_len),
    .span    (head_span),
    .need    (head_need)
  );

  assign head_ready = (fill_cnt >= head_need);
  assign take_beat  = in_valid & room & ~flush;
  assign take_insn  = head_ready & out_ready & ~flush;

  vlx_window #(
    .BUF_BYTES  (BUF_BYTES),
    .FILL_BYTES (FILL_BYTES),
    .CNT_W      (CNT_W)
  ) u_win (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .push       (take_beat),
    .push_bytes (in_bytes),
    .pop        (take_insn),
    .pop_mid    (head_len == LEN_16),
    .pop_span   (head_span),
    .head       (head),
    .fill_cnt   (fill_cnt),
    .room       (room)
  );

  vlx_assemble u_asm (
    .head (head),
    .len  (head_len),
    .insn (out_insn)
  );

  assign in_ready  = room;
  assign out_valid = head_ready;
  assign out_len   = head_len;

endmodule

// File: rtl/vlx_checker.sv
module vlx_checker #(
  parameter int BUF_BYTES  = 12,
  parameter int FILL_BYTES = 4,
  parameter int CNT_W      = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [63:0]      out_insn,
  input logic [1:0]       out_len,
  input logic [CNT_W-1:0] fill_cnt
);

  function automatic int unsigned span_of(input logic [1:0] code);
    return 2 * (32'(code) + 1);
  endfunction

  logic push_w;
  logic pop_w;
  assign push_w = in_valid & in_ready & ~flush;
  assign pop_w  = out_valid & out_ready & ~flush;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fill_cnt) <= 32'(BUF_BYTES));  // R7

  AST_BEAT_APPENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (push_w && !pop_w) |=> (32'(fill_cnt) == 32'($past(fill_cnt)) + 32'(FILL_BYTES)));  // R7

  AST_PAIR_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (push_w && pop_w) |=>
      (32'(fill_cnt) + span_of($past(out_len)) == 32'($past(fill_cnt)) + 32'(FILL_BYTES)));  // R11

  AST_VALID_COVERED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (32'(fill_cnt) >= 32'd4 && 32'(fill_cnt) >= span_of(out_len)));  // R6

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush) |=>
      (out_valid && $stable(out_insn) && $stable(out_len)));  // R8

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!out_valid && in_ready && fill_cnt == '0));  // R9

  AST_SHORT_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_insn[63:59] == 5'b00000) |-> (out_len == 2'b00));  // R1

  AST_SHORT_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_len == 2'b00) |-> (out_insn[47:0] == 48'h0));  // R2

endmodule

bind varlen_extract vlx_checker #(
  .BUF_BYTES  (BUF_BYTES),
  .FILL_BYTES (FILL_BYTES),
  .CNT_W      (CNT_W)
) u_vlx_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush     (flush),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_insn  (out_insn),
  .out_len   (out_len),
  .fill_cnt  (fill_cnt)
);

// File: tb/test_varlen_extract.sv
`timescale 1ns/1ps
module test_varlen_extract;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_bytes = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_insn;
  logic [1:0]  out_len;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 1'b0;

  always #10 clk = ~clk;

  varlen_extract #(.BUF_BYTES(10), .FILL_BYTES(4)) i_varlen_extract (
    .clk, .rst_n, .flush, .in_valid, .in_ready, .in_bytes,
    .out_valid, .out_ready, .out_insn, .out_len
  );

  // first beat (bytes 3..0), second beat (bytes 7..4), length code, instruction
  typedef struct packed {
    logic [31:0] w0;
    logic [31:0] w1;
    logic [1:0]  len;
    logic [63:0] insn;
  } vec_t;

  localparam vec_t VECS [0:11] = '{
    '{32'h01223344, 32'h55667788, 2'b00, 64'h0122_0000_0000_0000},
    '{32'h05A1B2C3, 32'hD4E5F607, 2'b00, 64'h05A1_0000_0000_0000},
    '{32'hB9102030, 32'h40506070, 2'b11, 64'hB910_2030_4050_6070},
    '{32'hBE010203, 32'h04050607, 2'b11, 64'hBE01_0203_0405_0607},
    '{32'hE2ABCDEF, 32'h12345678, 2'b10, 64'hE2AB_CDEF_5678_0000},
    '{32'hE5001122, 32'h99887766, 2'b10, 64'hE500_1122_7766_0000},
    '{32'h265A6B7C, 32'h00000000, 2'b01, 64'h265A_6B7C_0000_0000},
    '{32'h44332211, 32'hAAAAAAAA, 2'b01, 64'h4433_2211_0000_0000},
    '{32'hFFEEDDCC, 32'h01020304, 2'b01, 64'hFFEE_DDCC_0000_0000},
    '{32'hB7000001, 32'hC0C1C2C3, 2'b01, 64'hB700_0001_0000_0000},
    '{32'hE8123456, 32'h0BADF00D, 2'b01, 64'hE812_3456_0000_0000},
    '{32'h08112233, 32'h44556677, 2'b01, 64'h0811_2233_0000_0000}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All drivers start and end at a falling edge.
  task automatic push_beat(input logic [31:0] w);
    in_valid = 1'b1;
    in_bytes = w;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic take_one();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 out_valid", 64'(out_valid), 64'd0);
    chk("R10 in_ready", 64'(in_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R1 class, R2..R5 assembly per class
    for (int v = 0; v < 12; v++) begin
      string tag;
      do_flush();
      push_beat(VECS[v].w0);
      push_beat(VECS[v].w1);
      case (VECS[v].len)
        2'b00:   tag = "R2 insn";
        2'b01:   tag = "R3 insn";
        2'b10:   tag = "R4 insn";
        default: tag = "R5 insn";
      endcase
      chk("R6 valid with 8 bytes", 64'(out_valid), 64'd1);
      chk("R1 length code", 64'(out_len), 64'(VECS[v].len));
      chk(tag, out_insn, VECS[v].insn);
      take_one();
    end

    // R6: a 48-bit head with only 4 bytes held is not ready
    do_flush();
    push_beat(32'hE2ABCDEF);
    chk("R6 48-bit short window", 64'(out_valid), 64'd0);
    push_beat(32'h12345678);
    chk("R6 48-bit complete", 64'(out_valid), 64'd1);

    // R2 with stall, back-pressure and leftover bytes 0-1
    do_flush();
    push_beat(32'h01AA2799);
    chk("R6 16-bit with 4 bytes", 64'(out_valid), 64'd1);
    chk("R2 16-bit head", out_insn, 64'h01AA_0000_0000_0000);
    push_beat(32'h11223344);
    chk("R8 held insn", out_insn, 64'h01AA_0000_0000_0000);
    chk("R8 held len", 64'(out_len), 64'd0);
    chk("R7 no room at 8 bytes", 64'(in_ready), 64'd0);
    take_one();
    chk("R2 bytes 0-1 kept, len", 64'(out_len), 64'd1);
    chk("R2 bytes 0-1 kept, insn", out_insn, 64'h3344_2799_0000_0000);
    chk("R7 room at 6 bytes", 64'(in_ready), 64'd1);
    take_one();
    chk("R6 two bytes left", 64'(out_valid), 64'd0);

    // R9: flush drops held bytes and the beat offered with it
    in_valid = 1'b1;
    in_bytes = 32'h00FFFFFF;
    do_flush();
    in_valid = 1'b0;
    chk("R9 out_valid after flush", 64'(out_valid), 64'd0);
    chk("R9 in_ready after flush", 64'(in_ready), 64'd1);
    push_beat(32'h08112233);
    chk("R9 fresh window", out_insn, 64'h0811_2233_0000_0000);

    // R11: hand-off and beat in the same cycle
    out_ready = 1'b1;
    in_valid  = 1'b1;
    in_bytes  = 32'h04ABCDEF;
    @(negedge clk);
    out_ready = 1'b0;
    in_valid  = 1'b0;
    chk("R11 valid after swap", 64'(out_valid), 64'd1);
    chk("R11 next insn", out_insn, 64'h04AB_0000_0000_0000);

    // R10: reset in mid-stream
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 mid-run reset valid", 64'(out_valid), 64'd0);
    chk("R10 mid-run reset ready", 64'(in_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);

    finish_run();
  end

endmodule